// File: doc/BRIEF.md
# External Interrupt Detector with Mask

This block watches a bank of asynchronous external interrupt lines and turns qualifying activity on each of them into a sticky pending flag. Each line has its own 3-bit trigger selector. The selector picks low level, high level, falling edge, rising edge or both edges. Each line also has a mask bit. A single request output goes high while any pending line is not masked.

Software controls the block through a simple write port. It writes one mode word per group of eight lines, one mask word, and a write-one-to-clear pending word. In the mask and pending words, the line bits start at bit position `LINE_BASE`. The bits below that position are reserved and have no effect.

Every input first passes through a two-flop synchronizer. Level and edge detection then works on the synchronized value and on a one-cycle-delayed copy of it.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, all pending flags are 0 and `irq_o` is 0. Every mask bit resets to 1 (masked), and every mode resets to 010 (falling edge).
- R2: An input change goes through two synchronizer flops. A qualifying change driven before clock edge E0 shows in `pend_o` after edge E2, and not after edge E1.
- R3: Mode 000 sets the pending flag while the synchronized line is low, and mode 001 sets it while the line is high. The flag is set again on every cycle that the level holds, so a clear does not remove it while the level persists.
- R4: Modes 010 and 011 set the pending flag on a high-to-low transition only.
- R5: Modes 100 and 101 set the pending flag on a low-to-high transition only.
- R6: Modes 110 and 111 set the pending flag on any transition.
- R7: A write to address g loads the modes of lines 8g to 8g+7. Line 8g+j takes its mode from data bits [4j+2:4j]. Bit 4j+3 is reserved and has no effect on detection.
- R8: A write to address NGRP (the number of mode groups, 2 by default) loads the mask. Line k uses data bit LINE_BASE+k, where 1 blocks the line and 0 lets it through. The bits below LINE_BASE are ignored.
- R9: A write to address NGRP+1 clears the pending flag of line k when data bit LINE_BASE+k is 1. A 0 in that bit leaves the flag as it is. The bits below LINE_BASE are ignored.
- R10: `irq_o` is the OR over all lines of (pending AND NOT mask). It follows a register update within the same cycle.
- R11: When a trigger and a clear of the same line fall on the same clock edge, the pending flag stays 1.
- R12: `pend_o[k]` shows the pending flag of line k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | N_LINES | Asynchronous external interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 32 | Register write data |
| pend_o | output | N_LINES | Pending flags, one per line |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a trigger and a software clear of the same line landing on the same clock edge. The event must come out of the synchronizer exactly in the cycle when the clear write lands. The bench drives a rising edge on one line and counts two falling clock edges. It then asserts the clear write so that it lands on the third rising edge, the one where the detector fires. After that it checks that the flag survived, and that a second clear removes it. The main sweep rotates all eight mode codes across all lines, with the reserved slot bit toggled, under pseudo-random input vectors, masks and partial clears.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int REG_W     = 32;
  localparam int SLOT_W    = 4;
  localparam int MODE_W    = 3;
  localparam int GRP_LINES = 8;
  localparam logic [MODE_W-1:0] MODE_RST = 3'b010;

  typedef enum logic [1:0] {
    TRG_LEVEL = 2'b00,
    TRG_FALL  = 2'b01,
    TRG_RISE  = 2'b10,
    TRG_BOTH  = 2'b11
  } trg_kind_e;

  function automatic logic trig_hit(logic [MODE_W-1:0] mode, logic prev, logic cur);
    trg_kind_e kind;
    kind = trg_kind_e'(mode[2:1]);
    case (kind)
      TRG_LEVEL: trig_hit = mode[0] ? cur : ~cur;
      TRG_FALL:  trig_hit = prev & ~cur;
      TRG_RISE:  trig_hit = ~prev & cur;
      default:   trig_hit = prev ^ cur;
    endcase
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/eint_regs.sv
module eint_regs #(
  parameter int N_LINES   = 16,
  parameter int LINE_BASE = 4,
  parameter int ADDR_W    = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    wr_addr_i,
  input  logic [eint_pkg::REG_W-1:0]           wr_data_i,
  output logic [N_LINES-1:0][eint_pkg::MODE_W-1:0] mode_o,
  output logic [N_LINES-1:0]                   mask_o,
  output logic [N_LINES-1:0]                   clr_o
);
  import eint_pkg::*;

  localparam int NGRP      = (N_LINES + GRP_LINES - 1) / GRP_LINES;
  localparam int MASK_ADDR = NGRP;
  localparam int CLR_ADDR  = NGRP + 1;

  logic [N_LINES-1:0][MODE_W-1:0] mode_q;
  logic [N_LINES-1:0]             mask_q;
  logic                           mask_we, clr_we;
  logic                           unused_data;

  assign mask_we     = wr_en_i && (wr_addr_i == ADDR_W'(MASK_ADDR));
  assign clr_we      = wr_en_i && (wr_addr_i == ADDR_W'(CLR_ADDR));
  assign unused_data = ^wr_data_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic grp_we;
    assign grp_we = wr_en_i && (wr_addr_i == ADDR_W'(g));
    for (genvar j = 0; j < GRP_LINES; j++) begin : g_slot
      if (g * GRP_LINES + j < N_LINES) begin : g_line
        // slot bit 3 is reserved (filter enable), not stored
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)     mode_q[g*GRP_LINES+j] <= MODE_RST;
          else if (grp_we) mode_q[g*GRP_LINES+j] <= wr_data_i[SLOT_W*j +: MODE_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (mask_we) mask_q <= wr_data_i[LINE_BASE +: N_LINES];
  end

  assign clr_o  = clr_we ? wr_data_i[LINE_BASE +: N_LINES] : '0;
  assign mode_o = mode_q;
  assign mask_o = mask_q;

  a_r8_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we |=> (mask_q == $past(wr_data_i[LINE_BASE +: N_LINES])));
endmodule

// File: rtl/eint_detect.sv
module eint_detect #(
  parameter int N_LINES = 16
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [N_LINES-1:0]                       cur_i,
  input  logic [N_LINES-1:0][eint_pkg::MODE_W-1:0] mode_i,
  output logic [N_LINES-1:0]                       set_o
);
  import eint_pkg::*;

  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_det
    assign set_o[k] = trig_hit(mode_i[k], prev_q[k], cur_i[k]);

    a_r6_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i[k][2:1] != 2'b00) && set_o[k]) |-> (cur_i[k] != prev_q[k]));
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int N_LINES   = 16,
  parameter int LINE_BASE = 4,
  parameter int ADDR_W    = $clog2((N_LINES + 7) / 8 + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [31:0]        wr_data_i,
  output logic [N_LINES-1:0] pend_o,
  output logic               irq_o
);
  import eint_pkg::*;

  logic [N_LINES-1:0]             sync_w, set_w, clr_w, mask_w;
  logic [N_LINES-1:0][MODE_W-1:0] mode_w;
  logic [N_LINES-1:0]             pend_q;

  eint_sync #(.W(N_LINES)) u_sync (
    .clk_i, .rst_ni, .async_i(line_i), .sync_o(sync_w)
  );

  eint_regs #(.N_LINES(N_LINES), .LINE_BASE(LINE_BASE), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode_w), .mask_o(mask_w), .clr_o(clr_w)
  );

  eint_detect #(.N_LINES(N_LINES)) u_det (
    .clk_i, .rst_ni, .cur_i(sync_w), .mode_i(mode_w), .set_o(set_w)
  );

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_w) | set_w;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ~mask_w);

  for (genvar k = 0; k < N_LINES; k++) begin : g_chk
    a_r9_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q[k]) |-> $past(clr_w[k]));
    a_r3_rise_needs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[k]) |-> $past(set_w[k]));
    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_w[k] |=> pend_q[k]);
  end
endmodule

// File: tb/sim_ext_irq_detect.sv
`timescale 1ns/1ps
module sim_ext_irq_detect;
  localparam int N = 16;
  localparam int B = 4;
  localparam int AW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] line = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] pend;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_detect #(.N_LINES(N), .LINE_BASE(B), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pend_o(pend), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic lvl(logic [2:0] c, logic v);
    return (c == 3'b000) ? ~v : (c == 3'b001) ? v : 1'b0;
  endfunction

  function automatic logic edg(logic [2:0] c, logic o, logic n);
    case (c[2:1])
      2'b01:   return o & ~n;
      2'b10:   return ~o & n;
      2'b11:   return o ^ n;
      default: return 1'b0;
    endcase
  endfunction

  logic [15:0] rng = 16'hACE1;
  function automatic logic [15:0] nxt(logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] code [N];
    logic [N-1:0] exp, mask, c, old;
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 pend", 32'(pend), 0);
    chk("R1 irq", 32'(irq), 0);
    // default falling mode: rise gives nothing, fall sets; mask reset blocks irq
    line[2] = 1; step(3);
    chk("R1 R4 no pend on rise", 32'(pend), 0);
    line[2] = 0; step(3);
    chk("R1 R4 pend on fall", 32'(pend), 32'h4);
    chk("R1 R8 masked after reset", 32'(irq), 0);
    wr(2, 32'h0000_000F);
    chk("R10 unmasked irq", 32'(irq), 1);
    wr(3, 32'h0000_000F);
    chk("R9 low bits ignored", 32'(pend), 32'h4);
    wr(3, 32'h0000_0040);
    chk("R9 clear", 32'(pend), 0);

    // sweep: every code on every line, reserved slot bit toggled
    for (int s = 0; s < 8; s++) begin
      for (int g = 0; g < 2; g++) begin
        logic [31:0] w;
        w = '0;
        for (int j = 0; j < 8; j++) begin
          code[8*g+j] = 3'((8*g + j + s) % 8);
          w |= 32'(code[8*g+j]) << (4*j);
          if (s % 2 == 1) w |= 32'h8 << (4*j);
        end
        wr(g, w);
      end
      rng = nxt(rng); mask = rng;
      wr(2, {12'h0, mask, 4'hF});
      step(2);
      wr(3, 32'hFFFF_FFFF);
      for (int k = 0; k < N; k++) exp[k] = lvl(code[k], line[k]);
      chk("R3 R7 level after clear", 32'(pend), 32'(exp));
      for (int t = 0; t < 20; t++) begin
        old = line;
        rng = nxt(rng); line = rng;
        step(3);
        for (int k = 0; k < N; k++)
          exp[k] = exp[k] | lvl(code[k], line[k]) | edg(code[k], old[k], line[k]);
        chk("R3 R4 R5 R6 R7 R12 pend", 32'(pend), 32'(exp));
        chk("R8 R10 irq", 32'(irq), 32'(|(exp & ~mask)));
        if (t % 5 == 4) begin
          rng = nxt(rng); c = rng;
          wr(3, {12'h0, c, 4'hF});
          for (int k = 0; k < N; k++) exp[k] = (exp[k] & ~c[k]) | lvl(code[k], line[k]);
          chk("R9 R3 partial clear", 32'(pend), 32'(exp));
          chk("R10 irq after clear", 32'(irq), 32'(|(exp & ~mask)));
        end
      end
      wr(2, 32'hFFFF_FFFF);
      chk("R8 all masked", 32'(irq), 0);
    end

    // all lines rising edge, inputs low, clean state
    line = '0; step(3);
    wr(0, 32'h4444_4444); wr(1, 32'h4444_4444);
    wr(2, 32'h0); wr(3, 32'hFFFF_FFFF);
    chk("R5 clean", 32'(pend), 0);
    // latency
    line[1] = 1; step(2);
    chk("R2 not yet after E1", 32'(pend[1]), 0);
    step(1);
    chk("R2 set after E2", 32'(pend[1]), 1);
    // set vs clear on the same edge
    wr(3, 32'hFFFF_FFFF);
    line[0] = 1; step(2);
    wr(3, 32'h0000_0010);
    chk("R11 set beats clear", 32'(pend[0]), 1);
    wr(3, 32'h0000_0010);
    chk("R9 clear after", 32'(pend[0]), 0);
    chk("R10 irq idle", 32'(irq), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule